// File: doc/BRIEF.md
# Playback Peak Limiter with Soft Mute

This block is a per-sample gain stage on a digital playback path. Each accepted sample is multiplied by an effective gain, and the result is saturated to the sample width and registered. The effective gain is the product of two unsigned fractional gains. The first is a ramp gain, which slides toward the programmed volume, or toward zero while mute is held. The second is a limiter gain, which drops whenever a scaled sample exceeds a magnitude threshold and later recovers in 6 dB steps.

All time constants are counted in accepted samples, not clock cycles, so they scale with the sample rate. The valid strobe marks each sample, and gain state changes only on strobed cycles. The decay code of the surrounding control register has the reset value `LIM_DECAY_RESET` (0011), which the package exports. One decay period is `DECAY_BASE << decay_code` samples. With the default base of 33, code 0 is about 0.75 ms at 44.1 kHz and code 1 is about 1.5 ms.

Top module: `playback_limiter`

## Requirements
- R1: After reset `out_valid` and `out_sample` are 0, and both gains are unity, 1.0 = 2^(GW-2) = 16384. With the limiter off, mute low and volume at unity, a sample comes out unchanged, including -32768 and 32767.
- R2: `out_valid` rises in the cycle after each `in_valid` cycle and is low in the cycle after each idle cycle. Gain state changes only on `in_valid` cycles.
- R3: The output is s = (x * g) >>> 14 with g = (ramp * limgain) >> 14, where the shift floors toward minus infinity. With `lim_en` low, limgain is unity, so only the volume acts.
- R4: When s is outside the signed 16-bit range, the output clamps to 32767 or -32768 and never wraps. A volume above unity, up to 65535 (just under 4.0), makes this happen.
- R5: With `lim_en` high and |s| > `threshold`, the current sample still leaves with the old gain. The limiter gain for the next sample becomes L - (L >> (attack_code + 1)), and the decay counter clears.
- R6: With `lim_en` high and |s| equal to `threshold` or below it, no attack occurs.
- R7: While the limiter gain is below unity and no sample exceeds the threshold, the gain doubles once every `33 << decay_code` accepted samples. The doubling is capped at unity.
- R8: While `lim_en` is low, each accepted sample resets the limiter gain to unity. A limited gain is therefore gone from the sample after the one taken with the limiter off.
- R9: While `mute` is high, the ramp gain falls by at most 256 (unity >> 6) per accepted sample and settles at exactly 0. The output is then 0.
- R10: After `mute` is released, the ramp gain climbs by 256 per accepted sample up to `volume`. A volume change takes the same gradual path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | DW | Signed input sample |
| lim_en | input | 1 | Limiter enable |
| decay_code | input | 4 | Recovery period code, period = 33 << code samples per 6 dB |
| attack_code | input | 3 | Attack shift minus one |
| threshold | input | DW-1 | Magnitude threshold, unsigned |
| mute | input | 1 | Soft mute request |
| volume | input | GW | Volume, unsigned with 2^(GW-2) as unity |
| out_valid | output | 1 | Output strobe |
| out_sample | output | DW | Signed, saturated output sample |

## Verification
The hardest state to reach is a limiter gain well below unity that then climbs back through several doubling boundaries. Getting there needs a burst over the threshold, then a long run of quiet samples counted exactly against the decay period, and all of this must happen after the ramp gain has settled. The stimulus first lets the ramp reach the target volume. It then sends two loud samples to stack two attacks, followed by more than 66 constant quiet samples. A reference model tracks the sample at which each 6 dB step should appear, and the checks compare against it. The same approach is used with a longer decay code and with a deeper attack shift.

// File: rtl/lim_pkg.sv
package lim_pkg;
   // reset value of the decay code field held by the control register
   localparam logic [3:0] LIM_DECAY_RESET = 4'b0011;
   // samples per 6 dB of recovery at code 0 (0.75 ms at 44.1 kHz)
   localparam int LIM_DECAY_BASE = 33;
endpackage

// File: rtl/lim_gain_ramp.sv
module lim_gain_ramp #(
   parameter int GW    = 16,
   parameter int UNITY = 16384,
   parameter int STEP  = 256
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic          mute,
   input  logic [GW-1:0] volume,
   output logic [GW-1:0] gain
);
   logic [GW-1:0] target;
   assign target = mute ? '0 : volume;

   generate
      if (STEP == 0) begin : g_hard
         // zero step selects an immediate gain switch
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   gain <= GW'(UNITY);
            else if (adv) gain <= target;
         end
      end else begin : g_ramp
         localparam logic [GW-1:0] STEP_G = GW'(STEP);
         logic [GW-1:0] nxt;
         always_comb begin
            nxt = gain;
            if (gain < target) begin
               nxt = ((target - gain) > STEP_G) ? gain + STEP_G : target;
            end else if (gain > target) begin
               nxt = ((gain - target) > STEP_G) ? gain - STEP_G : target;
            end
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   gain <= GW'(UNITY);
            else if (adv) gain <= nxt;
         end
      end
   endgenerate
endmodule

// File: rtl/lim_envelope.sv
module lim_envelope #(
   parameter int GW         = 16,
   parameter int UNITY      = 16384,
   parameter int DECAY_BASE = 33
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic          en,
   input  logic          over,
   input  logic [3:0]    decay_code,
   input  logic [2:0]    attack_code,
   output logic [GW-1:0] gain
);
   localparam int CW = $clog2(DECAY_BASE + 1) + 16;
   localparam logic [GW-1:0] UNITY_G = GW'(UNITY);

   logic [CW-1:0] period;
   logic [CW-1:0] cnt;
   logic [GW-1:0] attacked;
   logic [GW:0]   doubled;
   logic [GW-1:0] recovered;
   logic [3:0]    shamt;

   assign period    = CW'(DECAY_BASE) << decay_code;
   assign shamt     = {1'b0, attack_code} + 4'd1;
   assign attacked  = gain - (gain >> shamt);
   assign doubled   = {gain, 1'b0};
   assign recovered = (doubled > {1'b0, UNITY_G}) ? UNITY_G : doubled[GW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gain <= UNITY_G;
         cnt  <= '0;
      end else if (adv) begin
         if (!en) begin
            gain <= UNITY_G;
            cnt  <= '0;
         end else if (over) begin
            gain <= attacked;
            cnt  <= '0;
         end else if (gain < UNITY_G) begin
            if (cnt >= period - CW'(1)) begin
               gain <= recovered;
               cnt  <= '0;
            end else begin
               cnt <= cnt + CW'(1);
            end
         end else begin
            cnt <= '0;
         end
      end
   end
endmodule

// File: rtl/lim_gain_apply.sv
module lim_gain_apply #(
   parameter int DW   = 16,
   parameter int GW   = 16,
   parameter int FRAC = 14
) (
   input  logic signed [DW-1:0] x,
   input  logic        [GW-1:0] ramp_g,
   input  logic        [GW-1:0] lim_g,
   input  logic        [DW-2:0] threshold,
   output logic signed [DW-1:0] y,
   output logic                 over
);
   localparam int GE = GW + 1;
   localparam int PW = DW + GE + 1;
   localparam logic signed [PW-1:0] MAXP = PW'((64'sd1 <<< (DW - 1)) - 64'sd1);
   localparam logic signed [PW-1:0] MINN = -MAXP - PW'(1);

   logic [2*GW-1:0]        gprod;
   logic [GE-1:0]          geff;
   logic signed [PW-1:0]   xe;
   logic signed [PW-1:0]   ge_s;
   logic signed [PW-1:0]   prod;
   logic signed [PW-1:0]   scaled;
   logic        [PW-1:0]   mag;

   assign gprod  = ramp_g * lim_g;
   assign geff   = gprod[FRAC +: GE];
   assign xe     = PW'(x);
   assign ge_s   = $signed({{(PW-GE){1'b0}}, geff});
   assign prod   = xe * ge_s;
   assign scaled = prod >>> FRAC;
   assign mag    = scaled[PW-1] ? $unsigned(-scaled) : $unsigned(scaled);
   assign over   = mag > {{(PW-DW+1){1'b0}}, threshold};

   always_comb begin
      if (scaled > MAXP)      y = MAXP[DW-1:0];
      else if (scaled < MINN) y = MINN[DW-1:0];
      else                    y = scaled[DW-1:0];
   end
endmodule

// File: rtl/playback_limiter.sv
module playback_limiter #(
   parameter int DW         = 16,
   parameter int GW         = 16,
   parameter int RAMP_SHIFT = 6,
   parameter int DECAY_BASE = lim_pkg::LIM_DECAY_BASE
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic signed [DW-1:0] in_sample,
   input  logic                 lim_en,
   input  logic [3:0]           decay_code,
   input  logic [2:0]           attack_code,
   input  logic [DW-2:0]        threshold,
   input  logic                 mute,
   input  logic [GW-1:0]        volume,
   output logic                 out_valid,
   output logic signed [DW-1:0] out_sample
);
   localparam int FRAC  = GW - 2;
   localparam int UNITY = 1 << FRAC;
   localparam int STEP  = UNITY >> RAMP_SHIFT;

   if (DW < 8 || DW > 32) begin : g_chk_dw
      $error("playback_limiter: DW out of range");
   end
   if (GW < 8 || GW > 24) begin : g_chk_gw
      $error("playback_limiter: GW out of range");
   end
   if (RAMP_SHIFT < 0 || RAMP_SHIFT > FRAC) begin : g_chk_rs
      $error("playback_limiter: RAMP_SHIFT out of range");
   end
   if (DECAY_BASE < 1) begin : g_chk_db
      $error("playback_limiter: DECAY_BASE must be positive");
   end

   logic [GW-1:0]        ramp_gain;
   logic [GW-1:0]        lim_gain;
   logic signed [DW-1:0] scaled_y;
   logic                 over_thr;

   lim_gain_ramp #(.GW(GW), .UNITY(UNITY), .STEP(STEP)) u_ramp (
      .clk(clk), .rst_n(rst_n), .adv(in_valid), .mute(mute),
      .volume(volume), .gain(ramp_gain)
   );

   lim_gain_apply #(.DW(DW), .GW(GW), .FRAC(FRAC)) u_apply (
      .x(in_sample), .ramp_g(ramp_gain), .lim_g(lim_gain),
      .threshold(threshold), .y(scaled_y), .over(over_thr)
   );

   lim_envelope #(.GW(GW), .UNITY(UNITY), .DECAY_BASE(DECAY_BASE)) u_env (
      .clk(clk), .rst_n(rst_n), .adv(in_valid), .en(lim_en), .over(over_thr),
      .decay_code(decay_code), .attack_code(attack_code), .gain(lim_gain)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_sample <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_sample <= scaled_y;
      end
   end
endmodule

// File: rtl/playback_limiter_chk.sv
module playback_limiter_chk #(
   parameter int GW    = 16,
   parameter int UNITY = 16384,
   parameter int STEP  = 256
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          out_valid,
   input logic          lim_en,
   input logic          mute,
   input logic [GW-1:0] ramp_g,
   input logic [GW-1:0] lim_g
);
   assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_gains_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(lim_g) && $stable(ramp_g)));
   assert_lim_ceiling_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lim_g <= GW'(UNITY));
   assert_bypass_unity_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !lim_en) |=> (lim_g == GW'(UNITY)));
   assert_ramp_rate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (((ramp_g >= $past(ramp_g)) ? (ramp_g - $past(ramp_g))
                                                 : ($past(ramp_g) - ramp_g)) <= GW'(STEP)));
   assert_mute_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mute && ramp_g == '0) |=> (ramp_g == '0));
endmodule

bind playback_limiter playback_limiter_chk #(.GW(GW), .UNITY(UNITY), .STEP(STEP)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
   .lim_en(lim_en), .mute(mute), .ramp_g(ramp_gain), .lim_g(lim_gain)
);

// File: tb/test_playback_limiter.sv
module test_playback_limiter;
   localparam int     DW    = 16;
   localparam int     GW    = 16;
   localparam int     FRAC  = 14;
   localparam longint UNITY = 16384;
   localparam longint STEP  = 256;
   localparam longint BASE  = 33;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic                 rst_n;
   logic                 in_valid;
   logic signed [DW-1:0] in_sample;
   logic                 lim_en;
   logic [3:0]           decay_code;
   logic [2:0]           attack_code;
   logic [DW-2:0]        threshold;
   logic                 mute;
   logic [GW-1:0]        volume;
   logic                 out_valid;
   logic signed [DW-1:0] out_sample;

   playback_limiter i_playback_limiter (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .lim_en(lim_en), .decay_code(decay_code), .attack_code(attack_code),
      .threshold(threshold), .mute(mute), .volume(volume),
      .out_valid(out_valid), .out_sample(out_sample)
   );

   // control values applied with the next sample
   bit     c_en;
   int     c_dcode, c_acode, c_thr, c_vol;
   bit     c_mute;
   // reference state
   longint m_r, m_l, m_cnt;
   int     total = 0, bad = 0;
   int     exp_q[$];
   string  tag_q[$];
   bit     sent_q;

   task automatic check(input bit ok, input string tag, input longint act, input longint expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   function automatic longint model(input longint x);
      longint g, s, y, mag, tgt, per;
      bit over;
      g = (m_r * m_l) >>> FRAC;
      s = (x * g) >>> FRAC;
      y = (s > 32767) ? 32767 : ((s < -32768) ? -32768 : s);
      mag = (s < 0) ? -s : s;
      over = c_en && (mag > c_thr);
      per = BASE << c_dcode;
      if (!c_en) begin
         m_l = UNITY; m_cnt = 0;
      end else if (over) begin
         m_l = m_l - (m_l >> (c_acode + 1)); m_cnt = 0;
      end else if (m_l < UNITY) begin
         if (m_cnt == per - 1) begin
            m_l = (2 * m_l > UNITY) ? UNITY : 2 * m_l; m_cnt = 0;
         end else m_cnt++;
      end else m_cnt = 0;
      tgt = c_mute ? 0 : c_vol;
      if (m_r < tgt) m_r = (tgt - m_r > STEP) ? m_r + STEP : tgt;
      else if (m_r > tgt) m_r = (m_r - tgt > STEP) ? m_r - STEP : tgt;
      return y;
   endfunction

   task automatic send(input int x, input string tag);
      @(negedge clk);
      lim_en      = c_en;
      decay_code  = 4'(c_dcode);
      attack_code = 3'(c_acode);
      threshold   = 15'(c_thr);
      mute        = c_mute;
      volume      = 16'(c_vol);
      in_valid    = 1'b1;
      in_sample   = 16'(x);
      exp_q.push_back(int'(model(longint'(x))));
      tag_q.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   task automatic send_n(input int n, input int x, input string tag);
      for (int i = 0; i < n; i++) send(x, tag);
   endtask

   always @(posedge clk) sent_q <= rst_n && in_valid;

   // monitor: strobe timing and scoreboard comparison
   always @(negedge clk) begin
      if (rst_n) begin
         check(out_valid == sent_q, "R2 strobe", longint'(out_valid), longint'(sent_q));
         if (out_valid) begin
            if (exp_q.size() == 0) check(1'b0, "R2 unexpected output", 1, 0);
            else begin
               int    e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(out_sample == 16'(e), t, longint'(out_sample), longint'(e));
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_sample = '0;
      c_en = 1'b0; c_dcode = int'(lim_pkg::LIM_DECAY_RESET); c_acode = 0;
      c_thr = 32767; c_mute = 1'b0; c_vol = int'(UNITY);
      lim_en = 1'b0; decay_code = lim_pkg::LIM_DECAY_RESET; attack_code = '0;
      threshold = '1; mute = 1'b0; volume = 16'(UNITY);
      m_r = UNITY; m_l = UNITY; m_cnt = 0;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R1 reset valid", longint'(out_valid), 0);
      check(out_sample == '0, "R1 reset sample", longint'(out_sample), 0);
      rst_n = 1'b1;
      // R1 unity pass-through, with gaps for R2
      send(1234, "R1"); send(-32768, "R1"); idle(2);
      send(32767, "R1"); send(-1, "R1"); idle(1); send(0, "R1");
      // R3 volume at one half, ramped, limiter off
      c_vol = 8192;
      send_n(40, 10000, "R3 ramp"); send(-7, "R3"); send(-20001, "R3"); idle(3);
      // R4 volume near 4.0 saturates both directions
      c_vol = 65535;
      for (int i = 0; i < 130; i++) begin send(30000, "R4"); send(-30000, "R4"); end
      send(5, "R4 small");
      // settle back to unity
      c_vol = int'(UNITY);
      send_n(200, 1000, "R10 volume ramp");
      // R5 attack with shift 1, R6 exact threshold
      c_en = 1'b1; c_thr = 8000; c_acode = 0; c_dcode = 0;
      send(20000, "R5 first loud"); send(20000, "R5 halved"); send(20000, "R5 quartered");
      c_thr = 5000;
      send(20000, "R6 equal threshold"); send(-20000, "R6 equal negative");
      // R7 recovery over two periods of 33 samples
      send_n(70, 1000, "R7 decay code 0");
      send(20000, "R7 full gain");
      // R5 deeper attack shift 3, then R7 with code 1
      c_acode = 2; c_thr = 4000;
      send(20000, "R5 shift 3"); send(20000, "R5 shift 3 again");
      c_dcode = 1;
      send_n(140, 800, "R7 decay code 1");
      // R8 disable restores unity
      c_acode = 0; c_thr = 1000;
      send(20000, "R8 attack"); send(20000, "R8 limited");
      c_en = 1'b0;
      send(20000, "R8 disabled"); send(20000, "R8 unity");
      // R9 soft mute and R10 release
      c_mute = 1'b1;
      send_n(70, 12000, "R9 mute ramp");
      idle(2);
      send(-32768, "R9 muted zero");
      c_mute = 1'b0;
      send_n(70, 12000, "R10 release ramp");
      send(-12345, "R10 restored");
      idle(4);
      check(exp_q.size() == 0, "R2 all outputs seen", exp_q.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule